// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit keeps the status byte of a serial nonvolatile memory and decides, on every cycle, whether an array byte write and a status write may proceed. A serial command engine in front of it decodes the opcodes and sends it single-cycle strobes. These strobes cover: set the write-enable latch, clear the latch, write the status byte, and end of a write-type command. The engine raises the end-of-write strobe when chip select rises to close a memory write or a status write.

The engine also supplies the current auto-incremented array address and the level of the external write-protect pin. The unit answers with two grants, one for the array and one for the status byte, and with the status byte used by the status-read command. The protection decision is combinational on the address presented, so each byte of a burst is judged on its own address. A burst may therefore run from an open range into a locked one. Retention of the nonvolatile bits is modelled as flops that reset to zero.

Top module: `sr_wprot`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: A set strobe makes bit 1 (write-enable latch) read 1 from the next cycle. A clear strobe makes it read 0 from the next cycle.
- R3: The end-of-write strobe clears bit 1 on the next cycle. An array byte write on its own leaves bit 1 unchanged, so a burst keeps its enable until chip select rises.
- R4: Bit 0 of the status byte always reads 0, and bit 1 always mirrors the write-enable latch.
- R5: A granted status write loads data bits 7..2 into status bits 7..2. Data bits 1 and 0 have no effect.
- R6: A status write that is not granted leaves the status byte unchanged.
- R7: While the write-enable latch is 0, both grants are 0.
- R8: Status bits 3..2 select the locked array range for a 13-bit address. 00 locks nothing. 01 locks 0x1800–0x1FFF. 10 locks 0x1000–0x1FFF. 11 locks every address. The array grant is 1 only when the latch is 1 and the address lies outside the locked range.
- R9: When status bit 7 is 1, the status grant requires the write-protect pin to be high. When bit 7 is 0 the pin is ignored. The pin never affects the array grant.
- R10: If a clear strobe or an end-of-write strobe arrives in the same cycle as a set strobe, the latch reads 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wel_set_i | input | 1 | Set write-enable latch strobe |
| wel_clr_i | input | 1 | Clear write-enable latch strobe |
| wr_end_i | input | 1 | End of a memory or status write command (chip select rise) |
| sr_wr_i | input | 1 | Status byte write strobe |
| sr_data_i | input | 8 | Status byte write data |
| arr_addr_i | input | 13 | Current array byte address |
| wp_pin_i | input | 1 | Write-protect pin level (high = writes permitted) |
| status_o | output | 8 | Status byte for the status-read command |
| arr_grant_o | output | 1 | Array byte write permitted at arr_addr_i |
| sr_grant_o | output | 1 | Status byte write permitted |

## Verification
The in-design assertions check the latch set and clear rules, the latch-off lockout of both grants, the full lock under range code 11, the pin lock of the status byte, and the hold of status bits 7..2 across writes that are not granted. These checks run on every cycle. The exact range boundaries, the masking of data bits 1..0, and a burst that crosses into a locked range are shown only by the bench. The bench uses directed scenarios and a random mix compared against a reference model.

// File: rtl/sr_wprot.sv
module sr_wprot #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              wr_end_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              wp_pin_i,
  output logic [7:0]        status_o,
  output logic              arr_grant_o,
  output logic              sr_grant_o
);

  logic       wel_q;
  logic [5:0] nv_q;
  logic       locked;
  logic [1:0] top2;

  assign top2 = arr_addr_i[ADDR_W-1 -: 2];

  always_comb begin
    unique case (nv_q[1:0])
      2'b00:   locked = 1'b0;
      2'b01:   locked = (top2 == 2'b11);
      2'b10:   locked = top2[1];
      default: locked = 1'b1;
    endcase
  end

  assign sr_grant_o  = wel_q && (!nv_q[5] || wp_pin_i);
  assign arr_grant_o = wel_q && !locked;
  assign status_o    = {nv_q, wel_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      nv_q  <= '0;
    end else begin
      if (sr_wr_i && sr_grant_o) nv_q <= sr_data_i[7:2];
      if (wel_clr_i || wr_end_i) wel_q <= 1'b0;
      else if (wel_set_i)        wel_q <= 1'b1;
    end
  end

  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_set_i && !wel_clr_i && !wr_end_i) |=> status_o[1]); // R2
  AST_WEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_clr_i || wr_end_i) |=> !status_o[1]); // R10
  AST_NO_WEL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[1] |-> (!arr_grant_o && !sr_grant_o)); // R7
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_wr_i && sr_grant_o) |=> $stable(status_o[7:2])); // R6
  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3:2] == 2'b11) |-> !arr_grant_o); // R8
  AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7] && !wp_pin_i) |-> !sr_grant_o); // R9
  AST_BIT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[0]); // R4

endmodule

// File: tb/sr_wprot_bench.sv
module sr_wprot_bench;
  localparam int AW = 13;

  logic clk = 0;
  logic rst_n = 0;
  logic set_i = 0, clr_i = 0, end_i = 0, srw_i = 0, wp_i = 0;
  logic [7:0] dat_i = 0;
  logic [AW-1:0] addr_i = 0;
  logic [7:0] st;
  logic ag, sg;

  int n_chk = 0, n_bad = 0;
  logic m_wel = 0;
  logic [5:0] m_nv = 0;

  always #2 clk = ~clk;

  sr_wprot #(.ADDR_W(AW)) u_sr_wprot (
    .clk(clk), .rst_n(rst_n), .wel_set_i(set_i), .wel_clr_i(clr_i),
    .wr_end_i(end_i), .sr_wr_i(srw_i), .sr_data_i(dat_i),
    .arr_addr_i(addr_i), .wp_pin_i(wp_i),
    .status_o(st), .arr_grant_o(ag), .sr_grant_o(sg));

  function automatic logic f_locked(logic [1:0] bp, logic [AW-1:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a >= 13'h1800;
      2'b10: return a >= 13'h1000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] f_status();
    return {m_nv, m_wel, 1'b0};
  endfunction

  function automatic logic f_sr_ok();
    return m_wel && (!m_nv[5] || wp_i);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Drive inputs at negedge, check outputs, then update the model for the next edge.
  task automatic step(logic s, logic c, logic e, logic w, logic [7:0] d,
                      logic [AW-1:0] a, logic p);
    @(negedge clk);
    set_i = s; clr_i = c; end_i = e; srw_i = w; dat_i = d; addr_i = a; wp_i = p;
    #1;
    chk("R4/R5 status", st, f_status());
    chk("R8 array grant", {7'b0, ag}, {7'b0, m_wel && !f_locked(m_nv[1:0], a)});
    chk("R9 status grant", {7'b0, sg}, {7'b0, f_sr_ok()});
    if (w && f_sr_ok()) m_nv = d[7:2];
    if (c || e) m_wel = 0; else if (s) m_wel = 1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 8'h00, '0, 1);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", st, 8'h00);
    @(negedge clk) rst_n = 1;

    // R7: no latch, no grants; refused status write (R6)
    step(0, 0, 0, 1, 8'hFC, 13'h0000, 1);
    idle();
    chk("R6 refused write", st, 8'h00);
    // R2 set/clear
    step(1, 0, 0, 0, 0, 0, 1);
    idle();
    chk("R2 set", st, 8'h02);
    step(0, 1, 0, 0, 0, 0, 1);
    idle();
    chk("R2 clear", st, 8'h00);
    // R10 clear wins
    step(1, 0, 1, 0, 0, 0, 1);
    idle();
    chk("R10 end beats set", st, 8'h00);
    // R5 masked low bits, BP=01
    step(1, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 8'h07, 0, 1);
    step(0, 0, 1, 0, 0, 0, 1);
    idle();
    chk("R5 low bits ignored", st, 8'h04);
    // R3 burst crossing into locked range keeps latch until end
    step(1, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 13'h17FE, 1);
    step(0, 0, 0, 0, 0, 13'h17FF, 1);
    chk("R8 0x17FF open", {7'b0, ag}, 8'h01);
    step(0, 0, 0, 0, 0, 13'h1800, 1);
    chk("R8 0x1800 locked", {7'b0, ag}, 8'h00);
    chk("R3 burst keeps latch", st, 8'h06);
    step(0, 0, 1, 0, 0, 0, 1);
    idle();
    chk("R3 end clears", st, 8'h04);
    // BP=10 boundary and WPEN
    step(1, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 8'h88, 0, 1);
    step(0, 0, 0, 0, 0, 13'h0FFF, 0);
    chk("R8 0x0FFF open", {7'b0, ag}, 8'h01);
    chk("R9 pin low locks", {7'b0, sg}, 8'h00);
    step(0, 0, 0, 1, 8'h0C, 13'h1000, 0);
    chk("R8 0x1000 locked", {7'b0, ag}, 8'h00);
    idle();
    chk("R9 locked write ignored", st, 8'h8A);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R9 pin high opens", {7'b0, sg}, 8'h01);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 16;
      step(r < 3, r == 3, r == 4, r inside {[5:7]}, 8'($urandom),
           AW'($urandom), ($urandom % 4) != 0);
    end
    summary();
  end

  initial void'($urandom(32'h5EED));
endmodule